// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 16-bit logical address from a processor onto a 20-bit physical address in a 1 MB space. The logical space is divided into four zones, and the zone is chosen from the top nibble of the address. Zone 0 is the root zone: its addresses pass through zero-extended. Each of the other three zones has its own 8-bit segment value. That value is added to the address's top nibble to form the upper eight physical bits, and the low 12 bits pass through unchanged.

Two of the zone boundaries are set by the two nibbles of an 8-bit size register, at 4 KB granularity. The last boundary is fixed at logical 0xE000. A small register port writes and reads back the size register and the three segment registers. The translation path itself is combinational. The block also reports which zone an address fell into.

Top module: `seg_xlate`

## Requirements
- R1: An address in zone 0 produces `paddr` equal to `laddr` zero-extended to 20 bits.
- R2: The zone index `zone` is 3 when `laddr[15:12]` >= 0xE. Otherwise it is 2 when `laddr[15:12]` >= `size[3:0]`, otherwise 1 when `laddr[15:12]` >= `size[7:4]`, otherwise 0.
- R3: When a programmed boundary lies at or above a later boundary, the higher-numbered zone wins for the shared addresses, and the zone in between is empty.
- R4: In zones 1 to 3, `paddr[11:0]` equals `laddr[11:0]`, and `paddr[19:12]` equals the 8-bit segment value of that zone plus `laddr[15:12]`.
- R5: A segment sum that exceeds 8 bits wraps modulo 256, so the physical address wraps modulo 1 MB. No error is signalled.
- R6: Register select codes are 0 for the size register, 1 for the zone 1 segment, 2 for the zone 2 segment and 3 for the zone 3 segment. `rd_data` returns the register chosen by `rd_sel`, combinationally.
- R7: A write with `wr_en` high is captured on the rising clock edge and changes translation only after that edge. With `wr_en` low, no register changes.
- R8: After reset all four registers read zero, so every address translates to itself zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 size, 1..3 segments) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register read back |
| rd_data | output | 8 | Read-back data |
| laddr | input | 16 | Logical address |
| paddr | output | 20 | Physical address |
| zone | output | 2 | Zone the address fell into |

## Verification
The bench goes after the edges of each zone: the nibble just below a boundary and the nibble exactly on it. A design that used > where >= is needed would leave the boundary page in the earlier zone. Overlapping boundary settings are checked against a design that gives the lower zone priority, which would map an address through a zone that should be empty. The bench drives a segment of 0xFF with the top nibble set, so a design that widens the sum instead of wrapping would corrupt the upper physical bits. It also samples translation in the cycle a write is issued, to catch a write that bypasses the register and takes effect too early.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int LA_W  = 16,
  parameter int PA_W  = 20,
  parameter int SEG_W = 8,
  parameter logic [3:0] TOP_BND = 4'hE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [SEG_W-1:0] rd_data,
  input  logic [LA_W-1:0]  laddr,
  output logic [PA_W-1:0]  paddr,
  output logic [1:0]       zone
);
  localparam int OFF_W = LA_W - 4;

  logic [SEG_W-1:0] regs_q [4];
  logic [3:0]       top;
  logic [SEG_W-1:0] hi_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_sel] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_sel];
  assign top     = laddr[LA_W-1:OFF_W];

  always_comb begin
    if (top >= TOP_BND)               zone = 2'd3;
    else if (top >= regs_q[0][3:0])   zone = 2'd2;
    else if (top >= regs_q[0][7:4])   zone = 2'd1;
    else                              zone = 2'd0;
  end

  assign hi_sum = regs_q[zone] + SEG_W'(top);
  assign paddr  = (zone == 2'd0) ? PA_W'(laddr) : {hi_sum, laddr[OFF_W-1:0]};

  p_root_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zone == 2'd0 |-> paddr == PA_W'(laddr));

  p_top_zone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    top >= TOP_BND |-> zone == 2'd3);

  p_low_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    paddr[OFF_W-1:0] == laddr[OFF_W-1:0]);

  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_sel == 2'd0) |=> $stable(regs_q[0]));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == rd_sel) |=> rd_data == $past(wr_data) || rd_sel != $past(rd_sel));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0, zone;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] laddr = 0;
  logic [19:0] paddr;
  logic [7:0] m [4];
  int cmp = 0, bad = 0;

  always #2 clk = ~clk;

  seg_xlate u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .laddr(laddr),
    .paddr(paddr), .zone(zone));

  function automatic logic [1:0] exp_zone(input logic [15:0] a);
    if (a[15:12] >= 4'hE) return 2'd3;
    if (a[15:12] >= m[0][3:0]) return 2'd2;
    if (a[15:12] >= m[0][7:4]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [19:0] exp_pa(input logic [15:0] a);
    logic [1:0] z = exp_zone(a);
    logic [7:0] s;
    if (z == 0) return {4'h0, a};
    s = m[z] + {4'h0, a[15:12]};
    return {s, a[11:0]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    cmp++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic xl(input string r, input logic [15:0] a);
    laddr = a;
    #1;
    chk(r, {30'd0, zone}, {30'd0, exp_zone(a)});
    chk(r, {12'd0, paddr}, {12'd0, exp_pa(a)});
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    m[s] = d;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); #1;
      chk("R8", {24'd0, rd_data}, 32'd0);
    end
    xl("R8", 16'h1234);
    xl("R8", 16'hF00F);

    // R6 / R2 / R1 / R4: zone edges
    wr(2'd0, 8'h48); wr(2'd1, 8'h10); wr(2'd2, 8'h20); wr(2'd3, 8'h30);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i); #1;
      chk("R6", {24'd0, rd_data}, {24'd0, m[i]});
    end
    xl("R1", 16'h3FFF);
    xl("R2", 16'h4000);
    xl("R2", 16'h7ABC);
    xl("R4", 16'h8001);
    xl("R2", 16'hDFFF);
    xl("R2", 16'hE000);

    // R3: overlapping boundaries, zone 1 empty
    wr(2'd0, 8'h84);
    xl("R3", 16'h3000);
    xl("R3", 16'h4000);
    xl("R3", 16'h9000);
    chk("R3", {30'd0, zone}, 32'd2);
    // R3: both boundaries above 0xE, zones 1 and 2 empty before E
    wr(2'd0, 8'hFF);
    xl("R3", 16'hD123);
    xl("R3", 16'hE123);

    // R5: wrap modulo 1 MB
    wr(2'd3, 8'hFF);
    xl("R5", 16'hF5A5);
    chk("R5", {12'd0, paddr}, 32'h0E5A5);

    // R7: write not visible before edge, visible after; wr_en low ignored
    wr(2'd0, 8'h00);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd2; wr_data = 8'h77;
    laddr = 16'h1000; #1;
    chk("R7", {12'd0, paddr}, {12'd0, exp_pa(16'h1000)});
    @(negedge clk);
    wr_en = 0; m[2] = 8'h77;
    xl("R7", 16'h1000);
    wr_sel = 2'd2; wr_data = 8'h11;
    @(negedge clk); @(negedge clk);
    rd_sel = 2'd2; #1;
    chk("R7", {24'd0, rd_data}, 32'h77);
    xl("R7", 16'h2345);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 3)), 8'($urandom));
      @(negedge clk);
      xl("R4", 16'($urandom));
    end
    summary();
  end
endmodule